// File: doc/BRIEF.md
# Interruptible Iterative Integer Divider

This block divides a 32-bit or 16-bit dividend by a 16-bit divisor. Each operand pair can be read as unsigned or as two's complement. It produces one quotient bit per enabled clock cycle. The result is a 16-bit quotient, a 16-bit remainder and two status flags: one for a zero divisor and one for a quotient that does not fit in 16 bits.

A `start` pulse captures the operands and the two mode bits. From then on, the operation moves forward only on cycles where `step_en` is high. A full divide takes 19 enabled cycles:

- 1 preparation cycle, which takes magnitudes, records the signs and checks for a zero divisor.
- 16 shift-and-subtract cycles.
- 1 range-check cycle.
- 1 cycle that applies the signs and writes the results.

While `step_en` is low, every piece of partial state stays unchanged. The surrounding sequencer can therefore pause the divide for any number of cycles, for example to service an interrupt, and then resume it. The final answer is the same as for an unpaused run.

Top module: `iter_divider`

## Requirements
- R1: After reset, `busy`, `done`, `div_zero` and `overflow` are 0, and `quotient` and `remainder` are 0.
- R2: With a nonzero divisor, `done` rises exactly after the 19th cycle with `step_en` high following `start`. `busy` is high from `start` until then, and `done` and `busy` are never high together. `quotient` and `remainder` change only on the edge that raises `done`.
- R3: A cycle with `step_en` low and no `start` changes nothing visible: `busy` stays high, `done` stays low and the outputs hold. The result does not depend on where or for how long such pauses occur.
- R4: When `long_mode`=1 and `signed_mode`=0, the 32-bit dividend and the divisor are treated as unsigned. The quotient is floor(dividend/divisor) and the remainder is the residue.
- R5: When `long_mode`=0, only `dividend[15:0]` is used and `dividend[31:16]` has no effect. With `signed_mode`=0, the result is unsigned 16/16 division.
- R6: When `signed_mode`=1, the operands are two's complement. In 16-bit mode the sign is `dividend[15]`; in 32-bit mode it is `dividend[31]`. The quotient truncates toward zero, and a nonzero remainder carries the sign of the dividend.
- R7: A zero divisor sets `div_zero` and `done` after the first enabled cycle. `overflow` stays 0, and `quotient` and `remainder` keep their previous values.
- R8: `overflow` is set with `done` when the true quotient is out of range. The unsigned range is 0..65535 and the signed range is -32768..32767. In that case the quotient value is undefined.
- R9: A `start` while `busy` abandons the running divide and begins the new one. The new divide has the full 19-cycle count and the flags cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture operands and modes, begin a divide |
| long_mode | input | 1 | 1: 32-bit dividend, 0: 16-bit dividend |
| signed_mode | input | 1 | 1: two's complement operands |
| step_en | input | 1 | Advance the divide by one cycle |
| dividend | input | 32 | Dividend |
| divisor | input | 16 | Divisor |
| busy | output | 1 | A divide is in progress |
| done | output | 1 | Result valid, held until the next start |
| div_zero | output | 1 | Divisor was zero |
| overflow | output | 1 | Quotient out of range |
| quotient | output | 16 | Quotient |
| remainder | output | 16 | Remainder |

## Verification
The assertions check the following on every cycle:

- A stalled cycle freezes the visible state.
- `done` and `busy` exclude each other.
- The results change only as `done` rises.
- A zero-divisor completion never reports overflow.
- The number of enabled steps since `start` is exactly 19, or 1 for a zero divisor, whenever `done` rises.

The correctness of the quotient, the remainder and the overflow decision can only be shown by the bench. It sweeps dense grids of 16/16 operands in both sign modes, random and boundary 32/16 cases, random stall patterns during every divide, a long mid-divide pause and a restart while busy.

// File: rtl/div_pkg.sv
`timescale 1ns/1ps
package div_pkg;
    localparam int unsigned QW_DEF = 16;
    localparam int unsigned SETUP_STEPS = 1;
    localparam int unsigned TAIL_STEPS = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ITER,
        PH_CHECK,
        PH_FIXUP
    } phase_e;

    typedef struct packed {
        logic neg_q;
        logic neg_r;
        logic pre_ovf;
        logic zero;
    } prep_flags_t;
endpackage

// File: rtl/div_prep.sv
`timescale 1ns/1ps
module div_prep #(
    parameter int unsigned QW = 16
) (
    input  logic [2*QW-1:0]     dvd,
    input  logic [QW-1:0]       dvs,
    input  logic                long_m,
    input  logic                sgn,
    output logic [2*QW-1:0]     amag,
    output logic [QW-1:0]       dmag,
    output div_pkg::prep_flags_t flags
);
    logic [2*QW-1:0] ext;
    logic            dneg;

    always_comb begin
        ext  = long_m ? dvd : {{QW{sgn & dvd[QW-1]}}, dvd[QW-1:0]};
        flags.neg_r = sgn & ext[2*QW-1];
        amag = flags.neg_r ? (~ext + 1'b1) : ext;
        dneg = sgn & dvs[QW-1];
        dmag = dneg ? (~dvs + 1'b1) : dvs;
        flags.neg_q   = flags.neg_r ^ dneg;
        flags.zero    = (dvs == '0);
        // magnitude quotient needs more than QW bits
        flags.pre_ovf = (amag[2*QW-1:QW] >= dmag);
    end
endmodule

// File: rtl/div_step.sv
`timescale 1ns/1ps
module div_step #(
    parameter int unsigned QW = 16
) (
    input  logic [QW-1:0] prem,
    input  logic [QW-1:0] qsr,
    input  logic [QW-1:0] dmag,
    output logic [QW-1:0] prem_n,
    output logic [QW-1:0] qsr_n,
    output logic          spill
);
    logic [QW:0] trial;
    logic [QW:0] diff;
    logic [QW:0] sel;
    logic        fits;

    always_comb begin
        trial  = {prem, qsr[QW-1]};
        fits   = (trial >= {1'b0, dmag});
        diff   = trial - {1'b0, dmag};
        sel    = fits ? diff : trial;
        prem_n = sel[QW-1:0];
        spill  = sel[QW];
        qsr_n  = {qsr[QW-2:0], fits};
    end
endmodule

// File: rtl/div_fixup.sv
`timescale 1ns/1ps
module div_fixup #(
    parameter int unsigned QW = 16
) (
    input  logic [QW-1:0] mq,
    input  logic [QW-1:0] mr,
    input  logic          neg_q,
    input  logic          neg_r,
    input  logic          sgn,
    output logic [QW-1:0] q,
    output logic [QW-1:0] r,
    output logic          range_ovf
);
    localparam logic [QW-1:0] MOST_NEG = {1'b1, {(QW-1){1'b0}}};

    always_comb begin
        range_ovf = sgn & (neg_q ? (mq > MOST_NEG) : mq[QW-1]);
        q = neg_q ? (~mq + 1'b1) : mq;
        r = neg_r ? (~mr + 1'b1) : mr;
    end
endmodule

// File: rtl/iter_divider.sv
`timescale 1ns/1ps
module iter_divider #(
    parameter int unsigned QW = div_pkg::QW_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            long_mode,
    input  logic            signed_mode,
    input  logic            step_en,
    input  logic [2*QW-1:0] dividend,
    input  logic [QW-1:0]   divisor,
    output logic            busy,
    output logic            done,
    output logic            div_zero,
    output logic            overflow,
    output logic [QW-1:0]   quotient,
    output logic [QW-1:0]   remainder
);
    import div_pkg::*;

    localparam int unsigned CW = $clog2(QW);
    localparam logic [CW-1:0] LAST_BIT = CW'(QW - 1);

    phase_e          ph;
    logic [CW-1:0]   cnt;
    logic [2*QW-1:0] dvd_r;
    logic [QW-1:0]   dvs_r;
    logic            long_r, sgn_r;
    logic [QW-1:0]   prem, qsr, dmag_r;
    logic            negq_r, negr_r, ovf_acc;

    logic [2*QW-1:0] amag;
    logic [QW-1:0]   dmag;
    prep_flags_t     pflags;
    logic [QW-1:0]   prem_n, qsr_n;
    logic            spill;
    logic [QW-1:0]   q_fix, r_fix;
    logic            range_ovf;

    div_prep #(.QW(QW)) u_prep (
        .dvd(dvd_r), .dvs(dvs_r), .long_m(long_r), .sgn(sgn_r),
        .amag(amag), .dmag(dmag), .flags(pflags)
    );

    div_step #(.QW(QW)) u_step (
        .prem(prem), .qsr(qsr), .dmag(dmag_r),
        .prem_n(prem_n), .qsr_n(qsr_n), .spill(spill)
    );

    div_fixup #(.QW(QW)) u_fix (
        .mq(qsr), .mr(prem), .neg_q(negq_r), .neg_r(negr_r), .sgn(sgn_r),
        .q(q_fix), .r(r_fix), .range_ovf(range_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            cnt       <= '0;
            dvd_r     <= '0;
            dvs_r     <= '0;
            long_r    <= 1'b0;
            sgn_r     <= 1'b0;
            prem      <= '0;
            qsr       <= '0;
            dmag_r    <= '0;
            negq_r    <= 1'b0;
            negr_r    <= 1'b0;
            ovf_acc   <= 1'b0;
            done      <= 1'b0;
            div_zero  <= 1'b0;
            overflow  <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
        end else if (start) begin
            dvd_r    <= dividend;
            dvs_r    <= divisor;
            long_r   <= long_mode;
            sgn_r    <= signed_mode;
            ph       <= PH_SETUP;
            done     <= 1'b0;
            div_zero <= 1'b0;
            overflow <= 1'b0;
        end else if (step_en) begin
            unique case (ph)
                PH_SETUP: begin
                    if (pflags.zero) begin
                        div_zero <= 1'b1;
                        done     <= 1'b1;
                        ph       <= PH_IDLE;
                    end else begin
                        prem    <= amag[2*QW-1:QW];
                        qsr     <= amag[QW-1:0];
                        dmag_r  <= dmag;
                        negq_r  <= pflags.neg_q;
                        negr_r  <= pflags.neg_r;
                        ovf_acc <= pflags.pre_ovf;
                        cnt     <= '0;
                        ph      <= PH_ITER;
                    end
                end
                PH_ITER: begin
                    prem    <= prem_n;
                    qsr     <= qsr_n;
                    ovf_acc <= ovf_acc | spill;
                    cnt     <= cnt + 1'b1;
                    if (cnt == LAST_BIT) ph <= PH_CHECK;
                end
                PH_CHECK: begin
                    ovf_acc <= ovf_acc | range_ovf;
                    ph      <= PH_FIXUP;
                end
                PH_FIXUP: begin
                    quotient  <= q_fix;
                    remainder <= r_fix;
                    overflow  <= ovf_acc;
                    done      <= 1'b1;
                    ph        <= PH_IDLE;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign busy = (ph != PH_IDLE);
endmodule

// File: rtl/div_chk.sv
`timescale 1ns/1ps
module div_chk #(
    parameter int unsigned QW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          step_en,
    input logic          busy,
    input logic          done,
    input logic          div_zero,
    input logic          overflow,
    input logic [QW-1:0] quotient,
    input logic [QW-1:0] remainder
);
    localparam int unsigned FULL_STEPS = 1 + QW + 2;

    logic [7:0] steps;

    always_ff @(posedge clk) begin
        if (rst || start) steps <= '0;
        else if (busy && step_en) steps <= steps + 1'b1;
    end

    assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !step_en && !start) |=> (busy && !done && $stable(quotient) && $stable(remainder)));

    assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_result_on_done_R2: assert property (@(posedge clk) disable iff (rst)
        (!$stable(quotient) || !$stable(remainder)) |-> $rose(done));

    assert_full_count_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(done) && !div_zero) |-> (steps == 8'(FULL_STEPS)));

    assert_zero_one_step_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(done) && div_zero) |-> (steps == 8'd1));

    assert_zero_no_ovf_R7: assert property (@(posedge clk) disable iff (rst)
        div_zero |-> (done && !overflow));
endmodule

bind iter_divider div_chk #(.QW(QW)) u_chk (
    .clk(clk), .rst(rst), .start(start), .step_en(step_en), .busy(busy),
    .done(done), .div_zero(div_zero), .overflow(overflow),
    .quotient(quotient), .remainder(remainder)
);

// File: tb/iter_divider_tb.sv
`timescale 1ns/1ps
module iter_divider_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        long_mode = 1'b0;
    logic        signed_mode = 1'b0;
    logic        step_en = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        busy, done, div_zero, overflow;
    logic [15:0] quotient, remainder;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    iter_divider u_dut (
        .clk(clk), .rst(rst), .start(start), .long_mode(long_mode),
        .signed_mode(signed_mode), .step_en(step_en), .dividend(dividend),
        .divisor(divisor), .busy(busy), .done(done), .div_zero(div_zero),
        .overflow(overflow), .quotient(quotient), .remainder(remainder)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input bit lm, input bit sg, input logic [31:0] a, input logic [15:0] b);
        @(negedge clk);
        start = 1'b1; long_mode = lm; signed_mode = sg;
        dividend = a; divisor = b; step_en = 1'b0;
        @(negedge clk);
        start = 1'b0;
        long_mode = ~lm; signed_mode = ~sg; dividend = ~a; divisor = ~b;
    endtask

    // Runs enabled steps (with stalls) until done; returns enabled step count.
    task automatic run_steps(input int stall_pct, output int n);
        n = 0;
        while (!done && n < 30) begin
            step_en = ($urandom % 100) >= stall_pct;
            @(posedge clk);
            if (step_en) n++;
            @(negedge clk);
        end
        step_en = 1'b0;
    endtask

    task automatic divide(input bit lm, input bit sg, input logic [31:0] a,
                          input logic [15:0] b, input int stall_pct, input string req);
        longint ea, eb, eq, er;
        bit     eovf;
        int     n;
        logic [15:0] q_before, r_before;
        q_before = quotient; r_before = remainder;
        if (lm) ea = sg ? longint'($signed(a)) : longint'({32'b0, a});
        else    ea = sg ? longint'($signed(a[15:0])) : longint'({48'b0, a[15:0]});
        eb = sg ? longint'($signed(b)) : longint'({48'b0, b});
        pulse_start(lm, sg, a, b);
        run_steps(stall_pct, n);
        if (eb == 0) begin
            chk(n == 1 && done && div_zero && !overflow, "R7", n, 1);
            chk(quotient == q_before && remainder == r_before, "R7", quotient, q_before);
        end else begin
            eq = ea / eb;
            er = ea % eb;
            eovf = sg ? (eq > 32767 || eq < -32768) : (eq > 65535);
            chk(n == 19 && done && !busy && !div_zero, "R2", n, 19);
            chk(overflow == eovf, "R8", overflow, eovf);
            if (!eovf) begin
                chk(quotient == eq[15:0], req, quotient, eq[15:0]);
                chk(remainder == er[15:0], req, remainder, er[15:0]);
            end
        end
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [15:0] qh, rh;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !div_zero && !overflow, "R1", {busy, done, div_zero, overflow}, 0);
        chk(quotient == 0 && remainder == 0, "R1", quotient, 0);

        // R5 unsigned 16/16 grid, upper dividend bits randomized (ignored)
        for (int i = 0; i < 48; i++)
            for (int j = 0; j < 16; j++)
                divide(1'b0, 1'b0, {$urandom_range(0, 65535) & 32'hFFFF, 16'(i * 1367 + 5)} | (32'($urandom) << 16),
                       16'(j == 0 ? 0 : (j < 8 ? j : (j * 4099))), 30, "R5");

        // R6 signed 16/16 grid around zero and at extremes
        for (int i = -24; i < 24; i++)
            for (int j = -8; j < 8; j++)
                divide(1'b0, 1'b1, 32'($urandom) << 16 | 32'(16'(i * 1361)), 16'(j), 30, "R6");
        divide(1'b0, 1'b1, 32'h0000_8000, 16'hFFFF, 20, "R6");   // -32768/-1 overflow
        divide(1'b0, 1'b1, 32'h0000_8000, 16'h0001, 20, "R6");
        divide(1'b0, 1'b1, 32'h0000_7FFF, 16'h8000, 20, "R6");

        // R4 unsigned 32/16 random and boundary
        for (int k = 0; k < 200; k++)
            divide(1'b1, 1'b0, $urandom, 16'($urandom_range(1, 65535)), 40, "R4");
        divide(1'b1, 1'b0, 32'hFFFE_FFFF, 16'hFFFF, 25, "R4");     // q=65535
        divide(1'b1, 1'b0, 32'hFFFF_FFFF, 16'hFFFF, 25, "R8");     // q=65537
        divide(1'b1, 1'b0, 32'h0001_0000, 16'h0001, 25, "R8");

        // R6 signed 32/16 random (small quotients) and boundary
        for (int k = 0; k < 200; k++)
            divide(1'b1, 1'b1, 32'($signed(16'($urandom)) * $signed(16'($urandom_range(0, 3)))) + 32'($urandom_range(0, 7)),
                   16'($urandom), 40, "R6");
        divide(1'b1, 1'b1, 32'hC000_8000, 16'h7FFF, 25, "R6");     // -1073709056/32767 = -32768
        divide(1'b1, 1'b1, 32'hC000_0000, 16'h8000, 25, "R8");     // = 32768
        divide(1'b1, 1'b1, 32'h8000_0000, 16'hFFFF, 25, "R8");
        divide(1'b1, 1'b1, 32'hFFFF_FFF9, 16'h0002, 25, "R6");     // -7/2 = -3 r -1

        // R7 zero divisor keeps previous results
        divide(1'b1, 1'b0, 32'h1234_5678, 16'h0000, 0, "R7");

        // R3 long pause mid-divide
        pulse_start(1'b1, 1'b0, 32'd1000000, 16'd77);
        qh = quotient; rh = remainder;
        step_en = 1'b1;
        repeat (7) @(negedge clk);
        step_en = 1'b0;
        repeat (50) @(negedge clk);
        chk(busy && !done && quotient == qh && remainder == rh, "R3", {busy, done}, 2);
        run_steps(0, n);
        chk(n == 12 && quotient == 16'd12987 && remainder == 16'd1, "R3", quotient, 12987);

        // R9 restart while busy
        pulse_start(1'b1, 1'b0, 32'd50000, 16'd3);
        step_en = 1'b1;
        repeat (9) @(negedge clk);
        step_en = 1'b0;
        chk(busy && !done, "R9", busy, 1);
        pulse_start(1'b0, 1'b1, 32'h0000_FF9C, 16'd7);             // -100/7 = -14 r -2
        run_steps(25, n);
        chk(n == 19 && quotient == 16'hFFF2 && remainder == 16'hFFFE && !overflow, "R9", quotient, 16'hFFF2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule